// File: doc/BRIEF.md
# ASCII Command Bus Bridge

This block turns a stream of typed text commands into single-word transactions on a memory-mapped master port. Bytes arrive on a valid/ready stream, which may be fed by a USB FIFO bridge or by a UART receiver. The parser accepts two commands. A write is written `w <addr> <data>`, for example `w 0 12345678`. A read is written `r <addr>`, for example `r 0`. Each command ends with a carriage return or a line feed.

A write drives one write strobe on the master port and sends nothing back. A read drives one read strobe and waits for the slave to return data. It then sends the 32-bit word back as a line of uppercase hex text on an outgoing byte stream. A malformed line causes no bus activity. The block answers it with a short error line instead.

The master port follows a waitrequest/readdatavalid discipline. While a transaction or a reply is in flight, the input stream is held off. Commands are therefore handled strictly one at a time, in order.

Top module: `txt_cmd_master`

## Requirements
- R1: After reset, both bus strobes are low, `out_valid` is low and `in_ready` is high.
- R2: A line of the form `w`, space, address, space, data, end of line issues exactly one write at that address with that data. It sends no reply bytes.
- R3: A line of the form `r`, space, address, end of line issues exactly one read at that address. The reply is the returned word as 8 uppercase hex digits, most significant digit first, followed by 0x0D and 0x0A.
- R4: Address and data fields are hexadecimal with 1 to 8 digits, and the command letters and hex digits are accepted in either case. Each new digit shifts the value left by four bits, so a short field is zero-extended.
- R5: One or more spaces (0x20) may separate fields, and trailing spaces before the line end are allowed. A line ends at 0x0D or 0x0A. Empty lines, and a line feed that follows a carriage return, produce no output and no bus activity.
- R6: Any of the following is a malformed line: a command letter other than r/w, a missing space after the letter, a non-hex character in a field, a missing field, an extra field after a read address, or more than 8 digits in a field. The block skips the rest of such a line, then sends the three bytes 0x3F 0x0D 0x0A, and issues no bus transaction.
- R7: Only one strobe is high at a time. The strobe, address and write data stay steady while `bus_waitreq` is high. The strobe drops in the cycle after the slave accepts it.
- R8: After a read is accepted, the reply starts only once `bus_rvalid` is seen. While `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R9: `in_ready` is low from the end of a complete or malformed command until its transaction has finished and its reply has been fully sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Incoming command byte |
| in_valid | input | 1 | Incoming byte present |
| in_ready | output | 1 | Block takes the byte this cycle |
| bus_addr | output | ADDR_W | Master address |
| bus_wdata | output | DATA_W | Master write data |
| bus_read | output | 1 | Read strobe |
| bus_write | output | 1 | Write strobe |
| bus_waitreq | input | 1 | Slave stalls the current strobe |
| bus_rdata | input | DATA_W | Read data from the slave |
| bus_rvalid | input | 1 | Read data valid |
| out_data | output | 8 | Reply byte |
| out_valid | output | 1 | Reply byte present |
| out_ready | input | 1 | Receiver takes the reply byte |

## Verification
The two activities that can fall in the same cycle are the host presenting the first byte of the next command and the block finishing the previous one. The previous command finishes either when the slave accepts a write or when the last reply byte is taken under backpressure. The bench provokes this by sending several commands back to back, with wait states, read latency and a throttled `out_ready` all active. It judges the result by requiring that every bus transaction and every reply byte come out of the scoreboard queues in order, with none lost or duplicated. It also requires `in_ready` to be low whenever the slave accepts a strobe.

// File: rtl/txt_cmd_pkg.sv
package txt_cmd_pkg;

    localparam logic [7:0] ASC_SP = 8'h20;
    localparam logic [7:0] ASC_CR = 8'h0D;
    localparam logic [7:0] ASC_LF = 8'h0A;
    localparam logic [7:0] ASC_Q  = 8'h3F;

    typedef enum logic [3:0] {
        P_IDLE,   // waiting for a command letter
        P_GAP0,   // letter seen, a space must follow
        P_ADDR0,  // skipping spaces before the address
        P_ADDR,   // collecting address digits
        P_GAP1,   // after address: spaces, data start or line end
        P_DATA,   // collecting data digits
        P_TAIL,   // trailing spaces after data
        P_DROP,   // discarding a malformed line
        P_BUS,    // strobe on the master port
        P_RWAIT,  // waiting for read data
        P_REPLY   // reply being sent
    } pstate_e;

    typedef struct packed {
        logic       is_hex;
        logic [3:0] nib;
        logic       is_gap;
        logic       is_eol;
        logic       is_rd;
        logic       is_wr;
    } chr_info_t;

    function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction

endpackage

// File: rtl/txt_char_class.sv
module txt_char_class
    import txt_cmd_pkg::*;
(
    input  logic [7:0] ch,
    output chr_info_t  info
);

    always_comb begin
        info        = '0;
        info.is_gap = (ch == ASC_SP);
        info.is_eol = (ch == ASC_CR) || (ch == ASC_LF);
        info.is_rd  = (ch == 8'h72) || (ch == 8'h52);
        info.is_wr  = (ch == 8'h77) || (ch == 8'h57);
        if (ch >= 8'h30 && ch <= 8'h39) begin
            info.is_hex = 1'b1;
            info.nib    = ch[3:0];
        end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
            info.is_hex = 1'b1;
            info.nib    = ch[3:0] + 4'd9;
        end
    end

endmodule

// File: rtl/txt_reply_fmt.sv
module txt_reply_fmt
    import txt_cmd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_err,
    input  logic [DATA_W-1:0] word,
    output logic [7:0]        out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    localparam int NDIG = DATA_W / 4;
    localparam int IW   = $clog2(NDIG + 2);

    typedef struct packed {
        logic              busy;
        logic              err;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] sh;
    } fmt_t;

    fmt_t q, d;
    logic [IW-1:0] last_idx;

    assign last_idx = q.err ? IW'(2) : IW'(NDIG + 1);

    always_comb begin
        d = q;
        if (start) begin
            d.busy = 1'b1;
            d.err  = is_err;
            d.idx  = '0;
            d.sh   = word;
        end else if (q.busy && out_ready) begin
            if (q.idx == last_idx) begin
                d.busy = 1'b0;
            end else begin
                d.idx = q.idx + 1'b1;
                if (!q.err && q.idx < IW'(NDIG)) begin
                    d.sh = q.sh << 4;
                end
            end
        end
    end

    always_comb begin
        if (q.err) begin
            case (q.idx)
                IW'(0):  out_data = ASC_Q;
                IW'(1):  out_data = ASC_CR;
                default: out_data = ASC_LF;
            endcase
        end else if (q.idx < IW'(NDIG)) begin
            out_data = nib_to_ascii(q.sh[DATA_W-1 -: 4]);
        end else if (q.idx == IW'(NDIG)) begin
            out_data = ASC_CR;
        end else begin
            out_data = ASC_LF;
        end
    end

    assign out_valid = q.busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/txt_cmd_master.sv
module txt_cmd_master
    import txt_cmd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_read,
    output logic              bus_write,
    input  logic              bus_waitreq,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rvalid,
    output logic [7:0]        out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    localparam int NDIG = DATA_W / 4;
    localparam int CW   = $clog2(NDIG + 1);

    typedef struct packed {
        pstate_e           st;
        logic              wr;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [CW-1:0]     nd;
    } ctl_t;

    ctl_t q, d;

    chr_info_t         ci;
    logic              take;
    logic              fmt_start;
    logic              fmt_err;
    logic [DATA_W-1:0] fmt_word;
    logic              fmt_busy;

    txt_char_class u_cls (
        .ch   (in_data),
        .info (ci)
    );

    txt_reply_fmt #(.DATA_W(DATA_W)) u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fmt_start),
        .is_err    (fmt_err),
        .word      (fmt_word),
        .out_data  (out_data),
        .out_valid (fmt_busy),
        .out_ready (out_ready)
    );

    assign out_valid = fmt_busy;
    assign in_ready  = (q.st != P_BUS) && (q.st != P_RWAIT) && (q.st != P_REPLY);
    assign take      = in_valid && in_ready;
    assign bus_read  = (q.st == P_BUS) && !q.wr;
    assign bus_write = (q.st == P_BUS) && q.wr;
    assign bus_addr  = q.addr[ADDR_W-1:0];
    assign bus_wdata = q.data;

    always_comb begin
        d         = q;
        fmt_start = 1'b0;
        fmt_err   = 1'b0;
        fmt_word  = bus_rdata;
        case (q.st)
            P_IDLE: if (take) begin
                if (ci.is_rd || ci.is_wr) begin
                    d.wr = ci.is_wr;
                    d.st = P_GAP0;
                end else if (!ci.is_gap && !ci.is_eol) begin
                    d.st = P_DROP;
                end
            end
            P_GAP0: if (take) begin
                if (ci.is_gap)      d.st = P_ADDR0;
                else if (ci.is_eol) begin fmt_start = 1'b1; fmt_err = 1'b1; d.st = P_REPLY; end
                else                d.st = P_DROP;
            end
            P_ADDR0: if (take) begin
                if (ci.is_hex) begin
                    d.addr = DATA_W'(ci.nib);
                    d.nd   = CW'(1);
                    d.st   = P_ADDR;
                end else if (ci.is_eol) begin
                    fmt_start = 1'b1; fmt_err = 1'b1; d.st = P_REPLY;
                end else if (!ci.is_gap) begin
                    d.st = P_DROP;
                end
            end
            P_ADDR: if (take) begin
                if (ci.is_hex) begin
                    if (q.nd == CW'(NDIG)) begin
                        d.st = P_DROP;
                    end else begin
                        d.addr = {q.addr[DATA_W-5:0], ci.nib};
                        d.nd   = q.nd + 1'b1;
                    end
                end else if (ci.is_gap) begin
                    d.st = P_GAP1;
                end else if (ci.is_eol) begin
                    if (q.wr) begin fmt_start = 1'b1; fmt_err = 1'b1; d.st = P_REPLY; end
                    else      d.st = P_BUS;
                end else begin
                    d.st = P_DROP;
                end
            end
            P_GAP1: if (take) begin
                if (ci.is_hex && q.wr) begin
                    d.data = DATA_W'(ci.nib);
                    d.nd   = CW'(1);
                    d.st   = P_DATA;
                end else if (ci.is_eol) begin
                    if (q.wr) begin fmt_start = 1'b1; fmt_err = 1'b1; d.st = P_REPLY; end
                    else      d.st = P_BUS;
                end else if (!ci.is_gap) begin
                    d.st = P_DROP;
                end
            end
            P_DATA: if (take) begin
                if (ci.is_hex) begin
                    if (q.nd == CW'(NDIG)) begin
                        d.st = P_DROP;
                    end else begin
                        d.data = {q.data[DATA_W-5:0], ci.nib};
                        d.nd   = q.nd + 1'b1;
                    end
                end else if (ci.is_gap) begin
                    d.st = P_TAIL;
                end else if (ci.is_eol) begin
                    d.st = P_BUS;
                end else begin
                    d.st = P_DROP;
                end
            end
            P_TAIL: if (take) begin
                if (ci.is_eol)      d.st = P_BUS;
                else if (!ci.is_gap) d.st = P_DROP;
            end
            P_DROP: if (take && ci.is_eol) begin
                fmt_start = 1'b1; fmt_err = 1'b1; d.st = P_REPLY;
            end
            P_BUS: if (!bus_waitreq) begin
                d.st = q.wr ? P_IDLE : P_RWAIT;
            end
            P_RWAIT: if (bus_rvalid) begin
                fmt_start = 1'b1;
                fmt_word  = bus_rdata;
                d.st      = P_REPLY;
            end
            P_REPLY: if (!fmt_busy) begin
                d.st = P_IDLE;
            end
            default: d.st = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= P_IDLE;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/txt_cmd_master_chk.sv
module txt_cmd_master_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_read,
    input logic              bus_write,
    input logic              bus_waitreq,
    input logic [7:0]        out_data,
    input logic              out_valid,
    input logic              out_ready
);

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_read && bus_write));

    // R7
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read || bus_write) && bus_waitreq |=>
        $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_read) && $stable(bus_write));

    // R7
    strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read || bus_write) && !bus_waitreq |=> !bus_read && !bus_write);

    // R8
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9
    input_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read || bus_write || out_valid) |-> !in_ready);

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read || bus_write) |-> !out_valid);

endmodule

bind txt_cmd_master txt_cmd_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_read    (bus_read),
    .bus_write   (bus_write),
    .bus_waitreq (bus_waitreq),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready)
);

// File: tb/txt_cmd_master_tb.sv
module txt_cmd_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_read;
    logic        bus_write;
    logic        bus_waitreq = 1'b1;
    logic [31:0] bus_rdata = 32'h0;
    logic        bus_rvalid = 1'b0;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;

    always #2 clk = ~clk;

    txt_cmd_master u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_read(bus_read), .bus_write(bus_write),
        .bus_waitreq(bus_waitreq), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    typedef struct {
        bit          wr;
        logic [31:0] a;
        logic [31:0] d;
        string       tag;
    } bus_item_t;

    typedef struct {
        logic [7:0] b;
        string      tag;
    } byte_item_t;

    bus_item_t  exp_bus[$];
    byte_item_t exp_out[$];

    int n_chk = 0;
    int n_fail = 0;
    int wait_cfg = 0;
    int lat_cfg = 0;
    bit bp_mode = 1'b0;
    bit done = 1'b0;

    function automatic logic [31:0] rd_model(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input string tag);
        byte_item_t it;
        it.b = b; it.tag = tag;
        exp_out.push_back(it);
    endtask

    task automatic expect_write(input logic [31:0] a, input logic [31:0] dv, input string tag);
        bus_item_t it;
        it.wr = 1'b1; it.a = a; it.d = dv; it.tag = tag;
        exp_bus.push_back(it);
    endtask

    task automatic expect_read(input logic [31:0] a, input string tag);
        bus_item_t it;
        logic [31:0] v;
        logic [3:0]  n;
        it.wr = 1'b0; it.a = a; it.d = 32'h0; it.tag = tag;
        exp_bus.push_back(it);
        v = rd_model(a);
        for (int i = 7; i >= 0; i--) begin
            n = v[4*i +: 4];
            push_byte((n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n}), tag);
        end
        push_byte(8'h0D, tag);
        push_byte(8'h0A, tag);
    endtask

    task automatic expect_err(input string tag);
        push_byte(8'h3F, tag);
        push_byte(8'h0D, tag);
        push_byte(8'h0A, tag);
    endtask

    task automatic send_byte(input logic [7:0] b);
        in_data  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_line(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    endtask

    task automatic drain(input string tag);
        int t;
        t = 0;
        while ((exp_bus.size() != 0 || exp_out.size() != 0 || !in_ready || out_valid) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        chk(tag, "pending scoreboard items", exp_bus.size() + exp_out.size(), 32'd0);
    endtask

    // slave model and bus monitor
    int wcnt = 0;
    int rcnt = 0;
    bit pend = 1'b0;
    logic [31:0] paddr = 32'h0;
    always @(negedge clk) begin
        bus_rvalid = 1'b0;
        if (pend) begin
            if (rcnt == 0) begin
                bus_rvalid = 1'b1;
                bus_rdata  = rd_model(paddr);
                pend       = 1'b0;
            end else begin
                rcnt--;
            end
        end
        if (rst_n && (bus_read || bus_write)) begin
            if (wcnt > 0) begin
                bus_waitreq = 1'b1;
                wcnt--;
            end else begin
                bus_waitreq = 1'b0;
                chk("R9", "in_ready during strobe", {31'h0, in_ready}, 32'd0);
                if (exp_bus.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R6 unexpected bus transaction: actual wr=%0d addr %h expected none",
                             bus_write, bus_addr);
                end else begin
                    bus_item_t it;
                    it = exp_bus.pop_front();
                    chk(it.tag, "write strobe", {31'h0, bus_write}, {31'h0, it.wr});
                    chk(it.tag, "bus address", bus_addr, it.a);
                    if (it.wr) chk(it.tag, "write data", bus_wdata, it.d);
                end
                if (bus_read) begin
                    pend  = 1'b1;
                    rcnt  = lat_cfg;
                    paddr = bus_addr;
                end
            end
        end else begin
            bus_waitreq = 1'b1;
            wcnt        = wait_cfg;
        end
    end

    // reply monitor
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        out_ready = !bp_mode || (cyc % 3 != 0);
        if (rst_n && out_valid && out_ready) begin
            if (exp_out.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R5 unexpected reply byte: actual %h expected none", out_data);
            end else begin
                byte_item_t it;
                it = exp_out.pop_front();
                chk(it.tag, "reply byte", {24'h0, out_data}, {24'h0, it.b});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "in_ready", {31'h0, in_ready}, 32'd1);
        chk("R1", "out_valid", {31'h0, out_valid}, 32'd0);
        chk("R1", "bus_read", {31'h0, bus_read}, 32'd0);
        chk("R1", "bus_write", {31'h0, bus_write}, 32'd0);

        // R2 basic write
        expect_write(32'h0, 32'h12345678, "R2");
        send_line("w 0 12345678\r");
        drain("R2");

        // R3 basic read
        expect_read(32'h0, "R3");
        send_line("r 0\n");
        drain("R3");

        // R4 mixed case, short address, R5 CR LF pair
        expect_write(32'h000001AB, 32'h00C0FFEE, "R4");
        send_line("W 1aB 00c0FFee\r\n");
        drain("R4");

        // R5 runs of spaces and trailing spaces
        expect_read(32'hDEADBEEF, "R5");
        send_line("R   DeadBeef   \r");
        drain("R5");

        // R5 empty lines are ignored
        send_line("\r\n\n  \r");
        drain("R5");

        // R6 malformed lines
        expect_err("R6");
        send_line("x 1\r");
        expect_err("R6");
        send_line("r 12g\r");
        expect_err("R6");
        send_line("w 5\r");
        expect_err("R6");
        send_line("r 123456789\r");
        expect_err("R6");
        send_line("r\r");
        expect_err("R6");
        send_line("r5\r");
        expect_err("R6");
        send_line("r 4 9\r");
        drain("R6");

        // R7 write with wait states
        wait_cfg = 3;
        expect_write(32'h10, 32'h7, "R7");
        send_line("w 10 7\r");
        drain("R7");

        // R8 read latency with output backpressure
        wait_cfg = 2;
        lat_cfg  = 4;
        bp_mode  = 1'b1;
        expect_read(32'hABC, "R8");
        send_line("r abc\r");
        drain("R8");

        // R9 back-to-back commands while busy
        expect_read(32'h4, "R9");
        expect_write(32'h8, 32'h1, "R9");
        expect_read(32'hC, "R9");
        expect_err("R9");
        expect_write(32'hFFFFFFFF, 32'h80000000, "R9");
        send_line("r 4\rw 8 1\rr c\rq\rw ffffffff 80000000\r");
        drain("R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule